// File: doc/BRIEF.md
# Banked Multiport Register File with Same-Cycle Forwarding

This block is the integer register file of a wide-issue processor. It holds 32 words of 32 bits. Ten primary read lanes and six primary write lanes each carry an address. The first three of each can also be switched into a 64-bit mode that moves an even/odd register pair as one operand. In that mode three extra high-word read outputs and three extra high-word write data inputs are used. The block therefore presents 13 read data outputs and 9 write data inputs. Internally it has only ten read lanes and six write lanes, spread over two banks.

The even-numbered registers sit in one bank and the odd-numbered registers sit in the other. A 64-bit access touches the even bank through its lane's even-bank port. Its high word goes through the same lane's odd-bank port, so the high-word outputs and inputs need no ports of their own. Each bank compares its read indices against the writes of the current cycle and forwards the newest data. A read issued in the same cycle as a write to that register therefore sees the new value. A read lane that is disabled, or that is not making a legal access, keeps its output at the last value it produced. This keeps the consumers downstream from switching.

Top module: `rf_multiport`

## Requirements
- R1: While reset is active and after it is released, every register reads as zero and every read output is zero until a lane returns a different value.
- R2: An enabled read lane in 32-bit mode returns, in the same cycle, the register selected by its address.
- R3: An enabled write lane in 32-bit mode stores its data word into the addressed register at the rising clock edge.
- R4: A 64-bit access requires lanes 0 to 2 with their wide flag set and an even address A. For a read, output k returns register A and output 10+k returns register A+1. For a write, data input k goes to register A and data input 6+k goes to register A+1.
- R5: When a register is written in a cycle, any enabled read of that register in the same cycle returns the data being written, not the stored value.
- R6: A 64-bit access with an odd address is ignored. The write changes no register. The read outputs of that lane, low and high, keep their previous values.
- R7: A read output whose lane is disabled holds its previous value. A high-word output whose paired lane is not making a legal 64-bit read also holds its previous value.
- R8: When several write lanes target the same register in a cycle, the highest-numbered lane's data is stored and is also the data forwarded to reads. A high-word write counts under its lane's number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 10 | Enable for each primary read lane |
| rd_addr | input | 10x5 | Register address for each primary read lane |
| rd_wide | input | 3 | 64-bit mode for read lanes 0 to 2 |
| rd_data | output | 13x32 | Read outputs: 0 to 9 primary, 10 to 12 high words of lanes 0 to 2 |
| wr_en | input | 6 | Enable for each write lane |
| wr_addr | input | 6x5 | Register address for each write lane |
| wr_wide | input | 3 | 64-bit mode for write lanes 0 to 2 |
| wr_data | input | 9x32 | Write data: 0 to 5 primary, 6 to 8 high words of lanes 0 to 2 |

## Verification
Some checks run on every cycle. Each bank checks that the word it forwards to a read lane is the word that register holds after the edge, which ties forwarding to write priority. It also checks that an unblocked winning write lands. Every read output is checked to stay put when its lane is idle, and the top level checks that odd-address 64-bit reads leave both outputs unchanged. Other behaviour only the bench scenarios can show: the correct register contents across long mixes of 32-bit and 64-bit traffic, the routing of high words to the right odd register, the reset values, and illegal writes that leave storage untouched.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_NREG  = 32;
    localparam int RF_XLEN  = 32;
    localparam int RF_NRP   = 10;
    localparam int RF_NWP   = 6;
    localparam int RF_NPAIR = 3;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;
endpackage

// File: rtl/rf_hold.sv
module rf_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] live,
    output logic [W-1:0] out
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         seen;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        out         = take ? live : hold_q.val;
        hold_d.val  = out;
        hold_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    // R7: an idle lane keeps showing the last operand it delivered
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.seen && !take) |-> (out == $past(out)));
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    parameter int NW    = 6,
    parameter int NR    = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NW-1:0]           we,
    input  logic [NW-1:0][IW-1:0]   widx,
    input  logic [NW-1:0][W-1:0]    wdata,
    input  logic [NR-1:0][IW-1:0]   ridx,
    output logic [NR-1:0][W-1:0]    rdata
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         live_d, live_q;

    // storage next state: later lanes overwrite earlier ones
    always_comb begin
        for (int e = 0; e < DEPTH; e++) mem_d[e] = mem_q[e];
        for (int k = 0; k < NW; k++) begin
            if (we[k]) mem_d[widx[k]] = wdata[k];
        end
        live_d = 1'b1;
    end

    // forwarding network with the same lane priority
    always_comb begin
        for (int j = 0; j < NR; j++) begin
            rdata[j] = mem_q[ridx[j]];
            for (int k = 0; k < NW; k++) begin
                if (we[k] && (widx[k] == ridx[j])) rdata[j] = wdata[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
            live_q <= 1'b0;
        end else begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= mem_d[e];
            live_q <= live_d;
        end
    end

    // lanes overridden by a higher-numbered lane on the same entry
    logic [NW-1:0] shadowed;
    always_comb begin
        for (int k = 0; k < NW; k++) begin
            shadowed[k] = 1'b0;
            for (int h = k + 1; h < NW; h++) begin
                if (we[h] && (widx[h] == widx[k])) shadowed[k] = 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NW; k++) begin : g_wchk
        // R3 / R8: the winning lane's word is what the entry holds next
        a_r8_winner_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && we[k] && !shadowed[k]) |=> (mem_q[$past(widx[k])] == $past(wdata[k])));
    end

    for (genvar j = 0; j < NR; j++) begin : g_rchk
        // R5: what a read sees this cycle is what the entry holds after the edge
        a_r5_forward_coherent: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |=> (mem_q[$past(ridx[j])] == $past(rdata[j])));
    end
endmodule

// File: rtl/rf_multiport.sv
module rf_multiport
    import rf_pkg::*;
#(
    parameter int NREG  = RF_NREG,
    parameter int XLEN  = RF_XLEN,
    parameter int NRP   = RF_NRP,
    parameter int NWP   = RF_NWP,
    parameter int NPAIR = RF_NPAIR,
    parameter int AW    = $clog2(RF_NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NRP-1:0]                rd_en,
    input  logic [NRP-1:0][AW-1:0]        rd_addr,
    input  logic [NPAIR-1:0]              rd_wide,
    output logic [NRP+NPAIR-1:0][XLEN-1:0] rd_data,
    input  logic [NWP-1:0]                wr_en,
    input  logic [NWP-1:0][AW-1:0]        wr_addr,
    input  logic [NPAIR-1:0]              wr_wide,
    input  logic [NWP+NPAIR-1:0][XLEN-1:0] wr_data
);
    localparam int NRD   = NRP + NPAIR;
    localparam int DEPTH = NREG / 2;
    localparam int IW    = AW - 1;

    logic [NWP-1:0]             ev_we,    od_we;
    logic [NWP-1:0][IW-1:0]     wr_idx;
    logic [NWP-1:0][XLEN-1:0]   ev_wdata, od_wdata;
    logic [NRP-1:0][IW-1:0]     rd_idx;
    logic [NRP-1:0][XLEN-1:0]   ev_rdata, od_rdata;
    logic [NRP-1:0]             lo_take;
    logic [NPAIR-1:0]           hi_take;

    // write lane steering onto the two banks
    for (genvar k = 0; k < NWP; k++) begin : g_wr
        logic wide_w;
        logic lane_ok;
        if (k < NPAIR) begin : g_pair
            assign wide_w              = wr_wide[k];
            assign od_wdata[k]         = wide_w ? wr_data[NWP+k] : wr_data[k];
        end else begin : g_solo
            assign wide_w              = 1'b0;
            assign od_wdata[k]         = wr_data[k];
        end
        assign lane_ok     = wr_en[k] && !(wide_w && wr_addr[k][0]);
        assign ev_we[k]    = lane_ok && (bank_e'(wr_addr[k][0]) == BANK_EVEN);
        assign od_we[k]    = lane_ok && ((bank_e'(wr_addr[k][0]) == BANK_ODD) || wide_w);
        assign wr_idx[k]   = wr_addr[k][AW-1:1];
        assign ev_wdata[k] = wr_data[k];
    end

    // read lanes: a lane's odd-bank port doubles as its high-word port
    for (genvar k = 0; k < NRP; k++) begin : g_rd
        logic wide_r;
        logic [XLEN-1:0] lo_live;
        if (k < NPAIR) begin : g_pair
            assign wide_r     = rd_wide[k];
            assign hi_take[k] = rd_en[k] && wide_r && !rd_addr[k][0];
            rf_hold #(.W(XLEN)) u_hi (
                .clk  (clk),
                .rst_n(rst_n),
                .take (hi_take[k]),
                .live (od_rdata[k]),
                .out  (rd_data[NRP+k])
            );
        end else begin : g_solo
            assign wide_r = 1'b0;
        end
        assign rd_idx[k]  = rd_addr[k][AW-1:1];
        assign lo_take[k] = rd_en[k] && !(wide_r && rd_addr[k][0]);
        assign lo_live    = rd_addr[k][0] ? od_rdata[k] : ev_rdata[k];
        rf_hold #(.W(XLEN)) u_lo (
            .clk  (clk),
            .rst_n(rst_n),
            .take (lo_take[k]),
            .live (lo_live),
            .out  (rd_data[k])
        );
    end

    rf_bank #(.DEPTH(DEPTH), .W(XLEN), .NW(NWP), .NR(NRP)) u_even (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ev_we),
        .widx (wr_idx),
        .wdata(ev_wdata),
        .ridx (rd_idx),
        .rdata(ev_rdata)
    );

    rf_bank #(.DEPTH(DEPTH), .W(XLEN), .NW(NWP), .NR(NRP)) u_odd (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (od_we),
        .widx (wr_idx),
        .wdata(od_wdata),
        .ridx (rd_idx),
        .rdata(od_rdata)
    );

    logic started_d, started_q;
    always_comb started_d = 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= started_d;
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pchk
        // R6: an odd-based 64-bit read leaves both outputs of the lane alone
        a_r6_odd_wide_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && rd_en[k] && rd_wide[k] && rd_addr[k][0])
            |-> ((rd_data[k] == $past(rd_data[k])) && (rd_data[NRP+k] == $past(rd_data[NRP+k]))));
    end

    // R1: outputs are zero while reset is held
    always_comb begin
        if (!rst_n) a_r1_reset_zero: assert (rd_data == '0);
    end
endmodule

// File: tb/rf_multiport_test.sv
module rf_multiport_test;
    localparam int NREG = 32, XLEN = 32, NRP = 10, NWP = 6, NPAIR = 3, AW = 5;
    localparam int NRD = NRP + NPAIR, NWR = NWP + NPAIR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NRP-1:0]             rd_en = '0;
    logic [NRP-1:0][AW-1:0]     rd_addr = '0;
    logic [NPAIR-1:0]           rd_wide = '0;
    logic [NRD-1:0][XLEN-1:0]   rd_data;
    logic [NWP-1:0]             wr_en = '0;
    logic [NWP-1:0][AW-1:0]     wr_addr = '0;
    logic [NPAIR-1:0]           wr_wide = '0;
    logic [NWR-1:0][XLEN-1:0]   wr_data = '0;

    always #10 clk = ~clk;

    rf_multiport uut (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data)
    );

    logic [XLEN-1:0] ref_mem  [NREG];
    logic            ref_set  [NREG];
    logic [XLEN-1:0] ref_hold [NRD];
    int n_checks = 0;
    int n_fail   = 0;
    bit reset_phase = 1'b0;

    function automatic bit wwide(input int k);
        return (k < NPAIR) && wr_wide[k];
    endfunction

    function automatic bit rwide(input int k);
        return (k < NPAIR) && rd_wide[k];
    endfunction

    // value seen by a read of register r this cycle, with forwarding by lane order
    function automatic logic [XLEN-1:0] fwd(input int r, output int nhit);
        logic [XLEN-1:0] v = ref_mem[r];
        nhit = 0;
        for (int k = 0; k < NWP; k++) begin
            if (wr_en[k] && !(wwide(k) && wr_addr[k][0])) begin
                if (int'(wr_addr[k]) == r) begin v = wr_data[k]; nhit++; end
                else if (wwide(k) && int'(wr_addr[k]) + 1 == r) begin v = wr_data[NWP+k]; nhit++; end
            end
        end
        return v;
    endfunction

    task automatic check(input string tag, input int p, input logic [XLEN-1:0] exp);
        n_checks++;
        if (rd_data[p] !== exp) begin
            n_fail++;
            $display("FAIL %s port %0d: got %h expected %h", tag, p, rd_data[p], exp);
        end
    endtask

    // sample mid-cycle, compare all ports, advance the model, move to next negedge
    task automatic cycle_check();
        logic [XLEN-1:0] exp [NRD];
        #5;
        for (int p = 0; p < NRD; p++) begin
            int k    = (p < NRP) ? p : p - NRP;
            bit hi   = (p >= NRP);
            bit odd  = rd_addr[k][0];
            bit bad  = rd_en[k] && rwide(k) && odd;
            bit take = hi ? (rd_en[k] && rwide(k) && !odd) : (rd_en[k] && !bad);
            int r    = hi ? int'(rd_addr[k]) + 1 : int'(rd_addr[k]);
            int nh   = 0;
            string tag;
            if (take) exp[p] = fwd(r, nh); else exp[p] = ref_hold[p];
            if (reset_phase)           tag = "R1";
            else if (bad)              tag = "R6";
            else if (!take)            tag = "R7";
            else if (hi || rwide(k))   tag = "R4";
            else if (nh > 1)           tag = "R8";
            else if (nh == 1)          tag = "R5";
            else if (ref_set[r])       tag = "R3";
            else                       tag = "R2";
            check(tag, p, exp[p]);
        end
        for (int p = 0; p < NRD; p++) ref_hold[p] = exp[p];
        for (int k = 0; k < NWP; k++) begin
            if (wr_en[k] && !(wwide(k) && wr_addr[k][0])) begin
                ref_mem[wr_addr[k]] = wr_data[k];
                ref_set[wr_addr[k]] = 1'b1;
                if (wwide(k)) begin
                    ref_mem[wr_addr[k] + 1] = wr_data[NWP+k];
                    ref_set[wr_addr[k] + 1] = 1'b1;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rd_en = '0; rd_wide = '0; wr_en = '0; wr_wide = '0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < NREG; r++) begin ref_mem[r] = '0; ref_set[r] = 1'b0; end
        for (int p = 0; p < NRD; p++) ref_hold[p] = '0;

        // R1: outputs zero under reset, registers zero after release
        repeat (2) @(negedge clk);
        reset_phase = 1'b1;
        #5; for (int p = 0; p < NRD; p++) check("R1", p, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_en = '1;
        for (int k = 0; k < NRP; k++) rd_addr[k] = AW'(k * 3);
        rd_wide = 3'b001;
        cycle_check();
        reset_phase = 1'b0;

        // R8: lanes 1 and 4 both hit register 5; lane 4 must win, also on forwarding
        idle_inputs();
        wr_en[1] = 1; wr_addr[1] = 5; wr_data[1] = 32'h1111_0001;
        wr_en[4] = 1; wr_addr[4] = 5; wr_data[4] = 32'h4444_0004;
        rd_en[0] = 1; rd_addr[0] = 5;
        cycle_check();
        idle_inputs(); rd_en[3] = 1; rd_addr[3] = 5;
        cycle_check();

        // R6: odd-based wide write changes nothing; wide read with odd base holds
        idle_inputs();
        wr_en[0] = 1; wr_wide[0] = 1; wr_addr[0] = 7; wr_data[0] = 32'hdead_0007; wr_data[NWP] = 32'hdead_0008;
        rd_en[2] = 1; rd_wide[2] = 1; rd_addr[2] = 9;
        cycle_check();
        idle_inputs(); rd_en[0] = 1; rd_addr[0] = 7; rd_en[1] = 1; rd_addr[1] = 8;
        cycle_check();

        // R4 + R5: wide write to pair 10/11 forwarded to a wide read the same cycle
        idle_inputs();
        wr_en[2] = 1; wr_wide[2] = 1; wr_addr[2] = 10; wr_data[2] = 32'haaaa_000a; wr_data[NWP+2] = 32'hbbbb_000b;
        rd_en[1] = 1; rd_wide[1] = 1; rd_addr[1] = 10;
        cycle_check();
        // R4 high half wins over a lower narrow lane on register 11 (R8)
        idle_inputs();
        wr_en[0] = 1; wr_addr[0] = 11; wr_data[0] = 32'h0;
        wr_en[1] = 1; wr_wide[1] = 1; wr_addr[1] = 10; wr_data[1] = 32'hc0c0_0010; wr_data[NWP+1] = 32'hc1c1_0011;
        rd_en[0] = 1; rd_wide[0] = 1; rd_addr[0] = 10;
        cycle_check();
        idle_inputs(); rd_en = '1; rd_wide = 3'b111;
        for (int k = 0; k < NRP; k++) rd_addr[k] = AW'(10 + k);
        cycle_check();

        // random mixes of narrow and wide traffic with frequent address conflicts
        for (int c = 0; c < 600; c++) begin
            for (int k = 0; k < NRP; k++) begin
                rd_en[k]   = ($urandom_range(0, 3) != 0);
                rd_addr[k] = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(0, 7)) : AW'($urandom);
            end
            for (int k = 0; k < NPAIR; k++) begin
                rd_wide[k] = ($urandom_range(0, 2) == 0);
                wr_wide[k] = ($urandom_range(0, 2) == 0);
            end
            for (int k = 0; k < NWP; k++) begin
                wr_en[k]   = ($urandom_range(0, 4) < 2);
                wr_addr[k] = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(0, 7)) : AW'($urandom);
            end
            for (int d = 0; d < NWR; d++) wr_data[d] = $urandom;
            cycle_check();
        end

        idle_inputs(); rd_en = '1;
        for (int base = 0; base < NREG; base += NRP) begin
            for (int k = 0; k < NRP; k++) rd_addr[k] = AW'((base + k) % NREG);
            cycle_check();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule